// File: doc/BRIEF.md
# Strided Bulk Memory Access Engine

This block puts a word-addressed RAM behind a set of valid/ready channels. A tagged command channel selects one of four operations: a single read, a single write, a bulk read or a bulk write. Separate channels carry the write data, a stride and an element count. Every operation returns its results on one valid/ready output channel. A read returns the stored word. A write returns a zero token that acknowledges it.

A bulk command captures a start address, a stride and a count. It then visits `count` locations, stepping by the stride each time. The address wraps around the memory. While a walk is in progress it owns the memory, and no new command is accepted until the remaining count reaches zero. The RAM is synchronous with a one-cycle read latency. Read words land in a registered output holding stage before valid is raised. Each step that produces output waits until that stage has room.

Top module: `stride_mem_engine`

## Requirements
- R1: A command with kind code 0 (single read) is accepted as soon as the output stage has room. The word stored at `cmd_addr` then appears on `out_data`, with `out_valid` high, two cycles after the accepting edge.
- R2: A command with kind code 1 (single write) is accepted only in a cycle where `wd_valid` is also high. The command and the data word are consumed on the same edge. The word is stored at `cmd_addr`, and a zero token is emitted on the next cycle.
- R3: A command with kind code 2 (bulk read) or 3 (bulk write) is accepted only when `stride_valid` and `count_valid` are both high. The command, stride and count are consumed on the same edge.
- R4: A bulk read emits, in order, the words at start, start+stride, start+2·stride and so on, for exactly `count` words.
- R5: A bulk write consumes one `wd_data` word per step. It stores the words at successive strided addresses and emits one zero token per stored word. Write data is never consumed outside a single write or a bulk-write step.
- R6: While a bulk transfer has elements remaining, `cmd_ready` stays low.
- R7: A bulk command with count 0 completes at once. It emits nothing, and the next command is accepted without waiting.
- R8: Every address computed during a walk wraps modulo the memory depth 2^AW.
- R9: When `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold on the next cycle. No word is emitted that was not requested.
- R10: During and right after reset, `out_valid` is low, and no command is accepted while `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_kind | input | 2 | 0 single read, 1 single write, 2 bulk read, 3 bulk write |
| cmd_addr | input | AW | Single-word address or bulk start address |
| wd_valid | input | 1 | Write data present |
| wd_ready | output | 1 | Write data consumed this cycle |
| wd_data | input | DW | Write data word |
| stride_valid | input | 1 | Stride present |
| stride_ready | output | 1 | Stride consumed this cycle |
| stride_data | input | AW | Address increment per bulk step |
| count_valid | input | 1 | Count present |
| count_ready | output | 1 | Count consumed this cycle |
| count_data | input | CW | Number of bulk elements |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | DW | Read word or zero acknowledgement |

## Verification
The bench goes after walks whose addresses cross the top of memory. A design that saturates or drops the carry returns words from the wrong locations there. It also tests zero-count bulk commands, where a design that treats zero as a full wrap emits 2^CW words or stalls forever. Commands are held pending during a bulk write. A design that lets them in mid-walk produces tokens and reads out of order. Stuttering `out_ready` patterns during bulk reads catch a design that overwrites the holding register, or double-steps the address when the read data arrives a cycle late. Writes offered without data, and bulk commands offered with only a stride, check that nothing is taken before all of its operands are present.

// File: rtl/smx_pkg.sv
package smx_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_BRD = 2'd2,
    OP_BWR = 2'd3
  } op_e;
endpackage

// File: rtl/smx_ram.sv
module smx_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single port, registered read data
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/smx_walker.sv
module smx_walker #(
  parameter int AW = 6,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_stride,
  input  logic [CW-1:0] ld_count,
  input  logic          ld_write,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          bulk_wr
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] stride_q;
  logic [CW-1:0] left_q;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
      wr_q     <= 1'b0;
    end else if (load) begin
      addr_q   <= ld_addr;
      stride_q <= ld_stride;
      left_q   <= ld_count;
      wr_q     <= ld_write;
    end else if (step) begin
      addr_q   <= addr_q + stride_q;   // wraps modulo 2**AW
      left_q   <= left_q - CW'(1);
    end
  end

  assign cur_addr = addr_q;
  assign busy     = (left_q != '0);
  assign bulk_wr  = wr_q;

  // R6
  step_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> busy);
  // R6
  load_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
  // R7
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (load && ld_count == '0) |=> !busy);
  // R4
  walk_keeps_going_chk: assert property (@(posedge clk) disable iff (rst)
    (load && ld_count != '0) |=> busy);
endmodule

// File: rtl/smx_outreg.sv
module smx_outreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (!out_valid || out_ready));
endmodule

// File: rtl/stride_mem_engine.sv
module stride_mem_engine #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  input  logic          stride_valid,
  output logic          stride_ready,
  input  logic [AW-1:0] stride_data,
  input  logic          count_valid,
  output logic          count_ready,
  input  logic [CW-1:0] count_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  import smx_pkg::*;

  op_e           kind;
  logic          rd_pend;
  logic          slot_free;
  logic          busy, bulk_wr;
  logic [AW-1:0] cur_addr;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_rdata;
  logic          issue_rd, load_tok;
  logic          walk_load, walk_step;
  logic          out_load;
  logic [DW-1:0] out_ld_data;

  assign kind = op_e'(cmd_kind);
  // room for exactly one result: nothing in flight and the holding stage free or draining
  assign slot_free = !rd_pend && (!out_valid || out_ready);

  always_comb begin
    cmd_ready    = 1'b0;
    wd_ready     = 1'b0;
    stride_ready = 1'b0;
    count_ready  = 1'b0;
    ram_we       = 1'b0;
    ram_addr     = cmd_addr;
    issue_rd     = 1'b0;
    load_tok     = 1'b0;
    walk_load    = 1'b0;
    walk_step    = 1'b0;
    if (!rst) begin
      if (busy) begin
        // an active walk owns the memory
        ram_addr = cur_addr;
        if (bulk_wr) begin
          if (wd_valid && slot_free) begin
            wd_ready  = 1'b1;
            ram_we    = 1'b1;
            load_tok  = 1'b1;
            walk_step = 1'b1;
          end
        end else if (slot_free) begin
          issue_rd  = 1'b1;
          walk_step = 1'b1;
        end
      end else if (cmd_valid) begin
        case (kind)
          OP_RD: if (slot_free) begin
            cmd_ready = 1'b1;
            issue_rd  = 1'b1;
          end
          OP_WR: if (slot_free && wd_valid) begin
            cmd_ready = 1'b1;
            wd_ready  = 1'b1;
            ram_we    = 1'b1;
            load_tok  = 1'b1;
          end
          default: if (stride_valid && count_valid) begin
            cmd_ready    = 1'b1;
            stride_ready = 1'b1;
            count_ready  = 1'b1;
            walk_load    = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_pend <= 1'b0;
    else     rd_pend <= issue_rd;
  end

  assign out_load    = load_tok | rd_pend;
  assign out_ld_data = rd_pend ? ram_rdata : '0;

  smx_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (wd_data),
    .rdata (ram_rdata)
  );

  smx_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .load      (walk_load),
    .ld_addr   (cmd_addr),
    .ld_stride (stride_data),
    .ld_count  (count_data),
    .ld_write  (kind == OP_BWR),
    .step      (walk_step),
    .cur_addr  (cur_addr),
    .busy      (busy),
    .bulk_wr   (bulk_wr)
  );

  smx_outreg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (out_load),
    .ld_data   (out_ld_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R1
  single_read_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && kind == OP_RD) |-> ##2 out_valid);
  // R2
  write_pairs_data_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && kind == OP_WR) |-> (wd_valid && wd_ready));
  // R2
  write_token_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && kind == OP_WR) |=> (out_valid && out_data == '0));
  // R3
  bulk_takes_three_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (kind == OP_BRD || kind == OP_BWR))
      |-> (stride_valid && stride_ready && count_valid && count_ready));
  // R5
  bulk_write_token_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wd_valid && wd_ready) |=> (out_valid && out_data == '0));
  // R6
  no_cmd_while_walking_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cmd_ready);
endmodule

// File: tb/sim_stride_mem_engine.sv
module sim_stride_mem_engine;
  localparam int  AW = 6;
  localparam int  DW = 16;
  localparam int  CW = 8;
  localparam int  DEPTH = 1 << AW;
  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [1:0]    cmd_kind = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          wd_valid = 1'b0, wd_ready;
  logic [DW-1:0] wd_data = '0;
  logic          stride_valid = 1'b0, stride_ready;
  logic [AW-1:0] stride_data = '0;
  logic          count_valid = 1'b0, count_ready;
  logic [CW-1:0] count_data = '0;
  logic          out_valid, out_ready = 1'b1;
  logic [DW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  stride_mem_engine #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .stride_valid(stride_valid), .stride_ready(stride_ready), .stride_data(stride_data),
    .count_valid(count_valid), .count_ready(count_ready), .count_data(count_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdy_mode = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] expq [$];
  logic [DW-1:0] exp_w;
  int            bw_left = 0;
  logic [AW-1:0] bw_addr = '0, bw_stride = '0;
  int            brd_left = 0;
  logic          prev_hold = 1'b0;
  logic [DW-1:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(16'hA000 ^ (i * 37));
  endfunction

  // reference model, compared every clock at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      prev_hold = 1'b0;
    end else begin
      cyc++;
      if (prev_hold)
        chk(out_valid && out_data == prev_data, "R9", out_data, prev_data, "stalled word not held");
      if (bw_left > 0 || brd_left > 1)
        chk(!cmd_ready, "R6", DW'(cmd_ready), '0, "command accepted mid-walk");
      if (cmd_valid && cmd_kind == 2'd1 && !wd_valid)
        chk(!cmd_ready, "R2", DW'(cmd_ready), '0, "write taken without data");
      if (cmd_valid && cmd_kind[1] && !(stride_valid && count_valid))
        chk(!cmd_ready, "R3", DW'(cmd_ready), '0, "bulk taken without operands");
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R9", out_data, '0, "unrequested output word");
        end else begin
          exp_w = expq.pop_front();
          chk(out_data == exp_w, "R1,R4,R5,R8", out_data, exp_w, "output word");
          if (brd_left > 0) brd_left--;
        end
      end
      if (cmd_valid && cmd_ready) begin
        case (cmd_kind)
          2'd0: expq.push_back(mdl[cmd_addr]);
          2'd1: begin
            chk(wd_valid && wd_ready, "R2", DW'(wd_ready), DW'(1), "data not consumed with write");
            mdl[cmd_addr] = wd_data;
            expq.push_back('0);
          end
          default: begin
            chk(stride_valid && stride_ready && count_valid && count_ready, "R3",
                DW'({stride_ready, count_ready}), DW'(3), "bulk operands not consumed");
            if (cmd_kind == 2'd2) begin
              brd_left = expq.size() + int'(count_data);
              for (int i = 0; i < int'(count_data); i++)
                expq.push_back(mdl[(int'(cmd_addr) + i * int'(stride_data)) % DEPTH]);
            end else begin
              bw_left   = int'(count_data);
              bw_addr   = cmd_addr;
              bw_stride = stride_data;
            end
          end
        endcase
      end else if (wd_valid && wd_ready) begin
        if (bw_left > 0) begin
          mdl[bw_addr] = wd_data;
          expq.push_back('0);
          bw_addr = bw_addr + bw_stride;
          bw_left--;
        end else begin
          chk(1'b0, "R5", wd_data, '0, "data consumed outside a write");
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  // output backpressure patterns
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      1:       out_ready = (cyc % 3) != 1;
      2:       out_ready = (cyc % 5) < 2;
      default: out_ready = 1'b1;
    endcase
  end

  task automatic send(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [AW-1:0] s, input logic [CW-1:0] n);
    cmd_kind = k; cmd_addr = a; cmd_valid = 1'b1;
    if (k == 2'd1) begin wd_valid = 1'b1; wd_data = d; end
    if (k[1]) begin
      stride_valid = 1'b1; stride_data = s;
      count_valid  = 1'b1; count_data  = n;
    end
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0; wd_valid = 1'b0; stride_valid = 1'b0; count_valid = 1'b0;
  endtask

  task automatic feed(input logic [DW-1:0] d);
    wd_valid = 1'b1; wd_data = d;
    do @(negedge clk); while (!wd_ready);
    @(posedge clk); #1;
    wd_valid = 1'b0;
  endtask

  // bulk write with a single read held pending for the whole walk
  task automatic bulk_write(input logic [AW-1:0] a, input logic [AW-1:0] s, input int n,
                            input logic [DW-1:0] seed, input logic [AW-1:0] lurk);
    send(2'd3, a, '0, s, CW'(n));
    cmd_kind = 2'd0; cmd_addr = lurk; cmd_valid = 1'b1;
    for (int i = 0; i < n; i++) feed(DW'(seed + i * 17));
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((expq.size() != 0 || out_valid) && t < 2000) begin
      @(posedge clk); t++;
    end
    #1;
    chk(expq.size() == 0, req, DW'(expq.size()), '0, "words still owed");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk(!out_valid, "R10", DW'(out_valid), '0, "out_valid in reset");
    chk(!cmd_ready, "R10", DW'(cmd_ready), '0, "cmd_ready in reset");
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(!out_valid && !cmd_ready, "R10", DW'({out_valid, cmd_ready}), '0, "after reset");
    @(posedge clk); #1;

    // R2: fill memory with single writes
    for (int i = 0; i < DEPTH; i++) send(2'd1, AW'(i), pat(i), '0, '0);
    drain("R2");

    // R1: single reads
    send(2'd0, AW'(0), '0, '0, '0);
    send(2'd0, AW'(63), '0, '0, '0);
    send(2'd0, AW'(17), '0, '0, '0);
    drain("R1");

    // R2: write offered without data is held off
    cmd_kind = 2'd1; cmd_addr = AW'(5); cmd_valid = 1'b1;
    repeat (4) @(posedge clk);
    #1 cmd_valid = 1'b0;
    send(2'd1, AW'(5), 16'h1234, '0, '0);
    send(2'd0, AW'(5), '0, '0, '0);
    drain("R2");

    // R3: bulk offered with stride only is held off
    cmd_kind = 2'd2; cmd_addr = AW'(0); cmd_valid = 1'b1;
    stride_valid = 1'b1; stride_data = AW'(1);
    repeat (4) @(posedge clk);
    #1 cmd_valid = 1'b0; stride_valid = 1'b0;
    send(2'd2, AW'(0), '0, AW'(1), CW'(3));
    drain("R3");

    // R4: strided bulk read
    send(2'd2, AW'(2), '0, AW'(3), CW'(5));
    drain("R4");

    // R8: bulk read crossing the top of memory
    send(2'd2, AW'(60), '0, AW'(7), CW'(6));
    drain("R8");

    // R5 and R6: bulk write with a read waiting behind it
    bulk_write(AW'(10), AW'(5), 4, 16'h5000, AW'(15));
    drain("R5");
    send(2'd2, AW'(10), '0, AW'(5), CW'(4));
    drain("R5");

    // R8: wrapping bulk write, read back
    bulk_write(AW'(62), AW'(3), 5, 16'h7000, AW'(1));
    send(2'd2, AW'(62), '0, AW'(3), CW'(5));
    drain("R8");

    // R7: zero-count bulk commands
    send(2'd2, AW'(7), '0, AW'(1), CW'(0));
    send(2'd0, AW'(7), '0, '0, '0);
    drain("R7");
    send(2'd3, AW'(9), '0, AW'(1), CW'(0));
    send(2'd0, AW'(9), '0, '0, '0);
    drain("R7");

    // R9: backpressure during bulk traffic
    rdy_mode = 1;
    send(2'd2, AW'(0), '0, AW'(1), CW'(12));
    send(2'd1, AW'(3), 16'hBEEF, '0, '0);
    send(2'd0, AW'(3), '0, '0, '0);
    drain("R9");
    rdy_mode = 2;
    bulk_write(AW'(20), AW'(1), 6, 16'h3300, AW'(22));
    send(2'd2, AW'(20), '0, AW'(1), CW'(6));
    drain("R9");
    rdy_mode = 0;
    repeat (4) @(posedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule